// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outbound path of a host bridge and turns system-bus addresses into PCI bus addresses. A fixed offset is first taken off the incoming address. The result is then compared in parallel against a small bank of programmable windows. Each window holds a base, a power-of-two size and a mapped PCI base. On a match, the upper address bits are replaced by the mapped base. If nothing matches, the address leaves unchanged with a miss flag.

Firmware programs the windows through a 32-bit register port before traffic starts. Each window has four words: range low, range high, map low and map high. The translation path takes one request per cycle and gives its result one cycle later. Windows 0 and 1 each offer two sizes. Windows 2 and 3 each offer four.

Top module: `ob_xlate`

## Requirements
- R1: After reset every window is invalid, every register reads zero, and every request misses with its address unchanged.
- R2: Window w occupies byte offsets 16*w to 16*w+15. The words are: +0 range low, +4 range high (base bits 63:32), +8 map low, +12 map high. The range low word has bit 0 = valid, bits 2:1 = size index and bits 31:3 = base bits 31:3. Read data appears on reg_rdata one cycle after reg_rd.
- R3: A window spans 128 MB shifted left by its size index. Windows 0 and 1 keep only bit 1 of the size index (bit 2 stores and reads as 0), so they allow 128 or 256 MB. Windows 2 and 3 allow 128, 256, 512 or 1024 MB.
- R4: Matching uses the effective address, which is in_addr minus AXI_OFFSET (default 0x4000_0000).
- R5: A request with in_addr below AXI_OFFSET never hits, even if its wrapped effective address falls inside a window.
- R6: A window whose valid bit is clear never matches.
- R7: On a hit, out_addr takes the mapped base bits at and above the window size, and the effective address bits below the window size.
- R8: Base and map bits below the selected window size are ignored both for matching and for the output.
- R9: When several valid windows match, the lowest-numbered window is used.
- R10: On a miss, out_miss=1, out_hit=0 and out_addr equals the request's in_addr.
- R11: Each cycle with in_valid produces exactly one result with out_valid one cycle later; back-to-back requests are accepted. A cycle without in_valid gives out_valid=0 with both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | RADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| in_valid | input | 1 | Translation request strobe |
| in_addr | input | 64 | Address to translate |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 64 | Translated or passed-through address |
| out_hit | output | 1 | A window matched |
| out_miss | output | 1 | No window matched |

## Verification
A corrupted size index moves a window's edge. This shows up on the next request near that edge as a wrong hit or miss, one cycle after the request. It also shows up in the readback of the range low word. A wrong valid bit or a wrong priority choice shows up as a wrong mapped base on the same one-cycle result. The stimulus therefore probes each window at its first and last byte, one byte past its end, and inside overlapping regions. A lost or extra result would show as a mismatch at once, because results must pair one for one with requests.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;
  localparam int unsigned SZ_IDX_W = 2;
  localparam int unsigned XADDR_W  = 64;

  typedef enum logic [1:0] {
    W_RNG_LO = 2'd0,
    W_RNG_HI = 2'd1,
    W_MAP_LO = 2'd2,
    W_MAP_HI = 2'd3
  } win_word_e;

  typedef struct packed {
    logic                valid;
    logic [SZ_IDX_W-1:0] size_idx;
    logic [XADDR_W-1:0]  base;
    logic [XADDR_W-1:0]  map;
  } win_cfg_t;
endpackage

// File: rtl/ob_win_regs.sv
module ob_win_regs
  import ob_xlate_pkg::*;
#(
  parameter int unsigned IDX_BITS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  win_word_e   wr_sel,
  input  logic [31:0] wr_data,
  input  win_word_e   rd_sel,
  output logic [31:0] rd_word,
  output win_cfg_t    cfg
);
  localparam logic [SZ_IDX_W-1:0] DROP_BITS =
    SZ_IDX_W'((1 << SZ_IDX_W) - (1 << IDX_BITS));
  localparam logic [31:0] LO_KEEP = ~(32'(DROP_BITS) << 1);

  logic [31:0] rng_lo_q, rng_hi_q, map_lo_q, map_hi_q;
  logic [31:0] rng_lo_d, rng_hi_d, map_lo_d, map_hi_d;

  always_comb begin
    rng_lo_d = rng_lo_q;
    rng_hi_d = rng_hi_q;
    map_lo_d = map_lo_q;
    map_hi_d = map_hi_q;
    if (wr_en) begin
      unique case (wr_sel)
        W_RNG_LO: rng_lo_d = wr_data & LO_KEEP;
        W_RNG_HI: rng_hi_d = wr_data;
        W_MAP_LO: map_lo_d = wr_data;
        W_MAP_HI: map_hi_d = wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng_lo_q <= '0;
      rng_hi_q <= '0;
      map_lo_q <= '0;
      map_hi_q <= '0;
    end else if (wr_en) begin
      rng_lo_q <= rng_lo_d;
      rng_hi_q <= rng_hi_d;
      map_lo_q <= map_lo_d;
      map_hi_q <= map_hi_d;
    end
  end

  always_comb begin
    unique case (rd_sel)
      W_RNG_LO: rd_word = rng_lo_q;
      W_RNG_HI: rd_word = rng_hi_q;
      W_MAP_LO: rd_word = map_lo_q;
      default:  rd_word = map_hi_q;
    endcase
  end

  assign cfg.valid    = rng_lo_q[0];
  assign cfg.size_idx = rng_lo_q[SZ_IDX_W:1];
  assign cfg.base     = {rng_hi_q, rng_lo_q[31:3], 3'b000};
  assign cfg.map      = {map_hi_q, map_lo_q};

  // R2: a high range word write lands in the base's upper half
  p_hi_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == W_RNG_HI) |=> (cfg.base[63:32] == $past(wr_data)));
endmodule

// File: rtl/ob_win_match.sv
module ob_win_match
  import ob_xlate_pkg::*;
#(
  parameter int unsigned MIN_LOG2 = 27
) (
  input  win_cfg_t           cfg,
  input  logic               chk_en,
  input  logic [XADDR_W-1:0] eff_addr,
  output logic               hit,
  output logic [XADDR_W-1:0] xlated
);
  logic [6:0]         shamt;
  logic [XADDR_W-1:0] hi_mask;

  always_comb begin
    shamt   = 7'(MIN_LOG2) + 7'(cfg.size_idx);
    hi_mask = ~((64'd1 << shamt) - 64'd1);
    hit     = chk_en && cfg.valid && (((eff_addr ^ cfg.base) & hi_mask) == '0);
    xlated  = (cfg.map & hi_mask) | (eff_addr & ~hi_mask);
  end
endmodule

// File: rtl/ob_prio_pick.sv
module ob_prio_pick
  import ob_xlate_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]              hits,
  input  logic [N-1:0][XADDR_W-1:0] cand,
  output logic                      any,
  output logic [N-1:0]              grant,
  output logic [XADDR_W-1:0]        pick
);
  always_comb begin
    grant = '0;
    pick  = '0;
    for (int w = N - 1; w >= 0; w--) begin
      if (hits[w]) begin
        grant    = '0;
        grant[w] = 1'b1;
        pick     = cand[w];
      end
    end
    any = |hits;
  end
endmodule

// File: rtl/ob_xlate.sv
module ob_xlate
  import ob_xlate_pkg::*;
#(
  parameter int unsigned NUM_WIN     = 4,
  parameter int unsigned NARROW_WINS = 2,
  parameter int unsigned MIN_LOG2    = 27,
  parameter logic [63:0] AXI_OFFSET  = 64'h0000_0000_4000_0000,
  localparam int unsigned WIN_IDX_W  = $clog2(NUM_WIN),
  localparam int unsigned RADDR_W    = WIN_IDX_W + 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               in_valid,
  input  logic [63:0]        in_addr,
  output logic               out_valid,
  output logic [63:0]        out_addr,
  output logic               out_hit,
  output logic               out_miss
);
  logic [WIN_IDX_W-1:0]           win_sel;
  win_word_e                      word_sel;
  logic [NUM_WIN-1:0][31:0]       rd_words;
  win_cfg_t                       cfgs  [NUM_WIN];
  logic [NUM_WIN-1:0]             valid_vec;
  logic [NUM_WIN-1:0]             hit_vec;
  logic [NUM_WIN-1:0][63:0]       cand;
  logic [NUM_WIN-1:0]             grant;
  logic                           any_hit;
  logic [63:0]                    pick_addr;
  logic [63:0]                    eff_addr;
  logic                           in_range;

  assign win_sel  = reg_addr[RADDR_W-1:4];
  assign word_sel = win_word_e'(reg_addr[3:2]);
  assign in_range = (in_addr >= AXI_OFFSET);
  assign eff_addr = in_addr - AXI_OFFSET;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int unsigned IDX_BITS = (w < NARROW_WINS) ? 1 : SZ_IDX_W;
    ob_win_regs #(.IDX_BITS(IDX_BITS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && (win_sel == WIN_IDX_W'(w))),
      .wr_sel  (word_sel),
      .wr_data (reg_wdata),
      .rd_sel  (word_sel),
      .rd_word (rd_words[w]),
      .cfg     (cfgs[w])
    );
    ob_win_match #(.MIN_LOG2(MIN_LOG2)) u_match (
      .cfg      (cfgs[w]),
      .chk_en   (in_range),
      .eff_addr (eff_addr),
      .hit      (hit_vec[w]),
      .xlated   (cand[w])
    );
    assign valid_vec[w] = cfgs[w].valid;
  end

  ob_prio_pick #(.N(NUM_WIN)) u_pick (
    .hits  (hit_vec),
    .cand  (cand),
    .any   (any_hit),
    .grant (grant),
    .pick  (pick_addr)
  );

  // next-state
  logic [31:0] rdata_d;
  logic        oval_d, ohit_d, omiss_d;
  logic [63:0] oaddr_d;

  always_comb begin
    rdata_d = rd_words[win_sel];
    oval_d  = in_valid;
    ohit_d  = in_valid && any_hit;
    omiss_d = in_valid && !any_hit;
    oaddr_d = any_hit ? pick_addr : in_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_miss  <= 1'b0;
    end else begin
      out_valid <= oval_d;
      out_hit   <= ohit_d;
      out_miss  <= omiss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr <= '0;
    end else if (in_valid) begin
      out_addr <= oaddr_d;
    end
  end

  // R11: one result per request, nothing when idle
  p_result_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_hit && !out_miss));
  // R10: a miss returns the request address untouched
  p_miss_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !any_hit) |=> (out_miss && out_addr == $past(in_addr)));
  // R5: below the offset never hits
  p_below_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr < AXI_OFFSET) |=> out_miss);
  // R9: at most one window is chosen
  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R6: a chosen window must be valid in the register bank
  p_grant_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~valid_vec) == '0);
endmodule

// File: tb/ob_xlate_bench.sv
module ob_xlate_bench;
  localparam logic [63:0] OFS = 64'h0000_0000_4000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        in_valid;
  logic [63:0] in_addr, out_addr;
  logic        out_valid, out_hit, out_miss;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic        q_hit [$];
  logic [63:0] q_addr[$];
  string       q_tag [$];

  always #10 clk = ~clk;

  ob_xlate u_ob_xlate (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
    .out_addr(out_addr), .out_hit(out_hit), .out_miss(out_miss)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int win, input int word, input logic [31:0] d);
    reg_wr    = 1'b1;
    reg_addr  = 6'(win * 16 + word * 4);
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input int win, input int word, input logic [31:0] exp,
                    input string tag);
    reg_rd   = 1'b1;
    reg_addr = 6'(win * 16 + word * 4);
    @(negedge clk);
    reg_rd   = 1'b0;
    chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  // driver: one request per call, back-to-back when called in a row
  task automatic req(input logic [63:0] a, input logic hit,
                     input logic [63:0] exp, input string tag);
    in_valid = 1'b1;
    in_addr  = a;
    q_hit.push_back(hit);
    q_addr.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (q_hit.size() == 0) begin
        chk(1'b0, "R11 unexpected result", out_addr, 64'h0);
      end else begin
        automatic logic        eh = q_hit.pop_front();
        automatic logic [63:0] ea = q_addr.pop_front();
        automatic string       t  = q_tag.pop_front();
        chk(out_hit == eh && out_miss == !eh && out_addr == ea,
            $sformatf("%s (hit=%0b exp_hit=%0b)", t, out_hit, eh), out_addr, ea);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_wdata = '0; in_valid = 1'b0; in_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'h0);
    rd(0, 0, 32'h0, "R1 window0 range low reset");
    rd(3, 3, 32'h0, "R1 window3 map high reset");
    req(64'h5000_0000, 1'b0, 64'h5000_0000, "R1 miss with no window");

    // window 2: effective base 0x1_0000_0000, 1 GB, map 0xAB_C000_0000
    wr(2, 0, 32'h0000_0007);
    wr(2, 1, 32'h0000_0001);
    wr(2, 2, 32'hC000_0000);
    wr(2, 3, 32'h0000_00AB);
    rd(2, 3, 32'h0000_00AB, "R2 map high readback");
    rd(2, 0, 32'h0000_0007, "R3 wide window keeps index 3");
    req(64'h1_4000_0000 + 64'h1234_5678, 1'b1, 64'hAB_D234_5678, "R4 R7 offset then map");
    req(64'h1_7FFF_FFFF, 1'b1, 64'hAB_FFFF_FFFF, "R3 last byte of 1 GB window");
    req(64'h1_8000_0000, 1'b0, 64'h1_8000_0000, "R10 one past 1 GB window");

    // window 3 covers the wrapped effective range
    wr(3, 1, 32'hFFFF_FFFF);
    wr(3, 0, 32'hC000_0007);
    wr(3, 3, 32'h0000_0002);
    req(64'h3FFF_FFFF, 1'b0, 64'h3FFF_FFFF, "R5 below offset does not wrap-hit");

    // window 0: index 3 written, only bit 1 kept -> 256 MB
    wr(0, 0, 32'h2000_0007);
    wr(0, 3, 32'h0000_0005);
    rd(0, 0, 32'h2000_0003, "R3 narrow window drops index bit 2");
    req(OFS + 64'h2FFF_FFFF, 1'b1, 64'h5_0FFF_FFFF, "R3 last byte of 256 MB");
    req(OFS + 64'h3000_0000, 1'b0, OFS + 64'h3000_0000, "R3 narrow window not 512 MB");

    // window 1: junk below window size in base and map
    wr(1, 0, 32'h6800_1001);
    wr(1, 2, 32'h0123_4567);
    wr(1, 3, 32'h0000_0007);
    req(OFS + 64'h6800_0010, 1'b1, 64'h7_0000_0010, "R8 low bits ignored");
    req(OFS + 64'h6FFF_FFFF, 1'b1, 64'h7_07FF_FFFF, "R8 128 MB top");
    wr(1, 0, 32'h6800_1000);
    req(OFS + 64'h6800_0010, 1'b0, OFS + 64'h6800_0010, "R6 invalid window ignored");

    // window 3 re-based to 0 with 1 GB, overlapping window 0
    wr(3, 1, 32'h0);
    wr(3, 0, 32'h0000_0007);
    wr(3, 3, 32'h0000_0009);
    req(OFS + 64'h2000_0100, 1'b1, 64'h5_0000_0100, "R9 lowest window wins");
    req(OFS + 64'h1000_0000, 1'b1, 64'h9_1000_0000, "R9 only window 3");
    req(OFS, 1'b1, 64'h9_0000_0000, "R4 effective zero at offset");
    req(OFS + 64'h3FFF_FFFF, 1'b1, 64'h9_3FFF_FFFF, "R11 back-to-back");

    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && out_hit == 1'b0 && out_miss == 1'b0,
        "R11 idle output", 64'(out_valid), 64'h0);
    chk(q_hit.size() == 0, "R11 all results delivered", 64'(q_hit.size()), 64'h0);
    done = 1'b1;
    summary();
  end
endmodule